// File: doc/BRIEF.md
# DRAM refresh scheduler with power-up initialisation

This block keeps a 64K-by-1 dynamic RAM alive. After reset it holds off all traffic for a programmable start-up pause, then runs a fixed number of dummy RAS strobes to wake the array, and only then raises `init_done`. From that point an interval timer asks for one row refresh per slot, so that all 128 refresh rows are visited once per retention window. Each refresh is a RAS-only cycle: the scheduler takes the RAS and address pins, presents the row from its own 7-bit row counter (address bit 7 forced low), and leaves CAS alone.

The access sequencer gets the pins through a request/grant pair. Refresh wins only at a cycle boundary, so an access that already holds the pins is never cut short. When the sequencer finishes a read and keeps CAS low to hold its output data, it raises `cas_hold`. If a refresh is owed at that moment, the scheduler does a hidden refresh: precharge with RAS high, a RAS strobe for the row, a second precharge, and then the grant comes back. Expiries that arrive while a refresh is still owed are counted, so no row is skipped. A normal refresh (not hidden) never begins until CAS has been seen high for a set number of cycles.

States: `ST_PAUSE` (start-up wait), `ST_IDLE` (pins free, no owner), `ST_ACCESS` (grant held), `ST_HPRE` (precharge before a hidden strobe), `ST_STROBE` (RAS low), `ST_REST` (RAS high after a strobe). Transitions: PAUSE→STROBE when the pause has elapsed and CAS is settled; IDLE→STROBE when a refresh is owed and CAS is settled, else IDLE→ACCESS on a request; ACCESS→IDLE when the request drops; ACCESS→HPRE when a refresh is owed and `cas_hold` is high; HPRE→STROBE and STROBE→REST when their timers end; REST→STROBE for the next wake-up strobe, REST→ACCESS after a hidden refresh, REST→IDLE otherwise.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ras_n` is 1, `pin_own` is 0, `acc_gnt` is 0 and `init_done` is 0.
- R2: No RAS strobe starts before PAUSE_CYC rising edges after reset; the first wake-up strobe begins on edge PAUSE_CYC.
- R3: Exactly WAKE_CNT wake-up strobes follow the pause, then `init_done` rises at the edge that ends the last rest; `acc_gnt` stays 0 while `init_done` is 0.
- R4: Every strobe holds `ras_n` low for exactly RAS_LOW_CYC cycles; the scheduler keeps `ras_n` high and owns the pins for at least RAS_HIGH_CYC cycles before it releases them, and before a strobe that follows its own precharge.
- R5: During a strobe `row_addr` is stable, its top bit is 0 and its low 7 bits equal the row counter; the counter starts at 0, steps by one after every strobe (wake-up strobes included) and wraps from 127 to 0.
- R6: The interval timer runs only after `init_done`; each INTERVAL_CYC cycles it marks one refresh as owed, and an owed refresh starts two edges after the expiry when the pins are free.
- R7: Expiries that come while refreshes are still owed are counted (up to 2^DEBT_W-1), and each one later receives its own refresh strobe on a new row.
- R8: While `acc_gnt` is high and `acc_req` stays high with `cas_hold` low, the grant holds and no refresh strobe starts.
- R9: In the idle state, an owed refresh is served before a pending `acc_req`.
- R10: A refresh that starts from idle or from the pause waits until `cas_n` has been high for CRP_CYC consecutive rising edges.
- R11: With the grant held, a refresh owed and `cas_hold` high, the scheduler drops `acc_gnt`, owns the pins with `ras_n` high for RAS_HIGH_CYC cycles, strobes for RAS_LOW_CYC cycles, rests for RAS_HIGH_CYC cycles, then gives the grant back.
- R12: `pin_own` is high exactly in the precharge, strobe and rest states, and never together with `acc_gnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access sequencer asks for the DRAM pins |
| cas_hold | input | 1 | Sequencer has ended a read with RAS high and is keeping CAS low |
| cas_n | input | 1 | Level of the CAS pin as seen at the DRAM |
| acc_gnt | output | 1 | Pins granted to the access sequencer |
| init_done | output | 1 | Start-up pause and wake-up strobes are complete |
| pin_own | output | 1 | Scheduler drives RAS and the address pins |
| ras_n | output | 1 | RAS strobe, active low, valid while `pin_own` is high |
| row_addr | output | ADDR_W | Row address for the refresh strobe |

## Verification
All outputs are decoded from the registered state, so a decision taken at edge n appears after edge n; an interval expiry first sets the owed count and the state machine reacts one edge later, and the CAS guard needs CRP_CYC edges of high CAS plus one edge for the state change. The bench counts rising edges from reset release, applies stimulus just after a falling edge and samples at the falling edge that follows the edge on which each result is due, including the cycles just before a due change to show it has not happened early. Longer checks (debt catch-up, row wrap) are observed through a strobe monitor on the RAS and address ports.

// File: rtl/dref_pkg.sv
`timescale 1ns/1ps
package dref_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_ACCESS,
        ST_HPRE,
        ST_STROBE,
        ST_REST
    } dref_state_e;
endpackage

// File: rtl/dref_cas_guard.sv
`timescale 1ns/1ps
// Counts consecutive cycles with CAS high; reports when the gap is long enough.
module dref_cas_guard #(
    parameter int CRP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cas_n,
    output logic cas_ok
);
    localparam int CW = $clog2(CRP_CYC + 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!cas_n)
            hi_cnt <= '0;
        else if (hi_cnt != CW'(CRP_CYC))
            hi_cnt <= hi_cnt + 1'b1;
    end

    assign cas_ok = (hi_cnt == CW'(CRP_CYC));
endmodule

// File: rtl/dref_due_ctr.sv
`timescale 1ns/1ps
// Interval timer plus owed-refresh counter (pending flag with debt).
module dref_due_ctr #(
    parameter int INTERVAL_CYC = 3120,
    parameter int DEBT_W       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic take,
    output logic due
);
    localparam int IW = $clog2(INTERVAL_CYC);

    logic [IW-1:0]     itv;
    logic [DEBT_W-1:0] owed;
    logic              tick;

    assign tick = run && (itv == IW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            itv <= '0;
        else if (tick)
            itv <= '0;
        else
            itv <= itv + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (!(&owed)) owed <= owed + 1'b1;
                2'b01:   if (owed != '0) owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign due = |owed;
endmodule

// File: rtl/dref_row_ctr.sv
`timescale 1ns/1ps
// Refresh row counter, wraps naturally at 2**ROW_W.
module dref_row_ctr #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (adv)
            row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
    parameter int PAUSE_CYC    = 100000,
    parameter int WAKE_CNT     = 8,
    parameter int INTERVAL_CYC = 3120,
    parameter int RAS_LOW_CYC  = 24,
    parameter int RAS_HIGH_CYC = 20,
    parameter int CRP_CYC      = 4,
    parameter int ROW_W        = 7,
    parameter int ADDR_W       = 8,
    parameter int DEBT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              cas_hold,
    input  logic              cas_n,
    output logic              acc_gnt,
    output logic              init_done,
    output logic              pin_own,
    output logic              ras_n,
    output logic [ADDR_W-1:0] row_addr
);
    import dref_pkg::*;

    localparam int PH_MAX = (PAUSE_CYC > RAS_LOW_CYC) ?
                            ((PAUSE_CYC > RAS_HIGH_CYC) ? PAUSE_CYC : RAS_HIGH_CYC) :
                            ((RAS_LOW_CYC > RAS_HIGH_CYC) ? RAS_LOW_CYC : RAS_HIGH_CYC);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int WK_W   = $clog2(WAKE_CNT + 1);

    dref_state_e       state, nxt;
    logic [PH_W-1:0]   ph, ph_lim;
    logic [WK_W-1:0]   wake_n;
    logic              hid_q, init_q;
    logic              ph_done, wake_last, strobe_end;
    logic              cas_ok, due;
    logic [ROW_W-1:0]  row;

    dref_cas_guard #(.CRP_CYC(CRP_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .cas_ok(cas_ok)
    );

    dref_due_ctr #(.INTERVAL_CYC(INTERVAL_CYC), .DEBT_W(DEBT_W)) u_due (
        .clk(clk), .rst_n(rst_n), .run(init_q),
        .take(strobe_end && init_q), .due(due)
    );

    dref_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(strobe_end), .row(row)
    );

    // Length of the timed phase for the current state
    always_comb begin
        unique case (state)
            ST_PAUSE:         ph_lim = PH_W'(PAUSE_CYC);
            ST_HPRE, ST_REST: ph_lim = PH_W'(RAS_HIGH_CYC);
            ST_STROBE:        ph_lim = PH_W'(RAS_LOW_CYC);
            default:          ph_lim = PH_W'(1);
        endcase
    end

    assign ph_done    = (ph == ph_lim - 1'b1);
    assign wake_last  = (wake_n == WK_W'(WAKE_CNT));
    assign strobe_end = (state == ST_STROBE) && ph_done;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PAUSE:  if (ph_done && cas_ok) nxt = ST_STROBE;
            ST_IDLE: begin
                if (due && cas_ok) nxt = ST_STROBE;
                else if (acc_req)  nxt = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (!acc_req)             nxt = ST_IDLE;
                else if (due && cas_hold) nxt = ST_HPRE;
            end
            ST_HPRE:   if (ph_done) nxt = ST_STROBE;
            ST_STROBE: if (ph_done) nxt = ST_REST;
            ST_REST: begin
                if (ph_done) begin
                    if (!init_q && !wake_last) begin
                        if (cas_ok) nxt = ST_STROBE;
                    end else if (hid_q) begin
                        nxt = ST_ACCESS;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PAUSE;
        else        state <= nxt;
    end

    // Phase timer, wake-up count, hidden and init flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= '0;
            wake_n <= '0;
            hid_q  <= 1'b0;
            init_q <= 1'b0;
        end else begin
            if (nxt != state)  ph <= '0;
            else if (!ph_done) ph <= ph + 1'b1;

            if (strobe_end && !init_q)
                wake_n <= wake_n + 1'b1;

            if (state == ST_ACCESS && nxt == ST_HPRE)
                hid_q <= 1'b1;
            else if (state == ST_REST && nxt != ST_REST)
                hid_q <= 1'b0;

            if (state == ST_REST && ph_done && !init_q && wake_last)
                init_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        acc_gnt   = (state == ST_ACCESS);
        pin_own   = (state == ST_HPRE) || (state == ST_STROBE) || (state == ST_REST);
        ras_n     = (state != ST_STROBE);
        init_done = init_q;
        row_addr  = {{(ADDR_W - ROW_W){1'b0}}, row};
    end
endmodule

// File: rtl/dref_chk.sv
`timescale 1ns/1ps
module dref_chk #(
    parameter int PAUSE_CYC    = 100000,
    parameter int RAS_LOW_CYC  = 24,
    parameter int RAS_HIGH_CYC = 20,
    parameter int CRP_CYC      = 4,
    parameter int ADDR_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_req,
    input logic              cas_hold,
    input logic              cas_n,
    input logic              acc_gnt,
    input logic              init_done,
    input logic              pin_own,
    input logic              ras_n,
    input logic [ADDR_W-1:0] row_addr
);
    localparam int SW = $clog2(PAUSE_CYC + 1);
    localparam int LW = $clog2(RAS_LOW_CYC + 2);
    localparam int HW = $clog2(RAS_HIGH_CYC + 2);
    localparam int CW = $clog2(CRP_CYC + 1);

    logic [SW-1:0] since;
    logic [LW-1:0] low_len;
    logic [HW-1:0] hi_len;
    logic [CW-1:0] cas_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since    <= '0;
            low_len  <= '0;
            hi_len   <= '0;
            cas_seen <= '0;
        end else begin
            if (since != SW'(PAUSE_CYC)) since <= since + 1'b1;
            if (!ras_n) low_len <= (low_len == LW'(RAS_LOW_CYC + 1)) ? low_len : low_len + 1'b1;
            else        low_len <= '0;
            if (pin_own && ras_n)
                hi_len <= (hi_len == HW'(RAS_HIGH_CYC + 1)) ? hi_len : hi_len + 1'b1;
            else
                hi_len <= '0;
            if (!cas_n)                         cas_seen <= '0;
            else if (cas_seen != CW'(CRP_CYC))  cas_seen <= cas_seen + 1'b1;
        end
    end

    // R2
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since < SW'(PAUSE_CYC)) |-> ras_n);

    // R3
    init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !acc_gnt);

    // R4
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && low_len != '0) |-> (low_len == LW'(RAS_LOW_CYC)));

    // R4
    pre_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && hi_len != '0) |-> (hi_len >= HW'(RAS_HIGH_CYC)));

    // R4
    rest_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_own && hi_len != '0) |-> (hi_len >= HW'(RAS_HIGH_CYC)));

    // R5
    addr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_own && !ras_n) |-> (row_addr[ADDR_W-1] == 1'b0));

    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && low_len != '0) |-> $stable(row_addr));

    // R8
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_gnt && acc_req && !cas_hold) |=> acc_gnt);

    // R10
    cas_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && low_len == '0 && hi_len == '0) |-> ($past(cas_seen) >= CW'(CRP_CYC)));

    // R12
    own_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_own && acc_gnt));
endmodule

bind dram_refresh_sched dref_chk #(
    .PAUSE_CYC(PAUSE_CYC), .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_HIGH_CYC(RAS_HIGH_CYC),
    .CRP_CYC(CRP_CYC), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .cas_hold(cas_hold), .cas_n(cas_n),
    .acc_gnt(acc_gnt), .init_done(init_done), .pin_own(pin_own), .ras_n(ras_n),
    .row_addr(row_addr)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    localparam int P  = 50;
    localparam int WK = 8;
    localparam int IV = 200;
    localparam int LO = 4;
    localparam int HI = 3;
    localparam int CR = 2;
    localparam int NT = 16;

    // cycle, expected {addr-check, ras_n, pin_own, init_done, addr[7:0]}, tag
    localparam int TB_CYC[NT] = '{0, 49, 50, 53, 54, 56, 57, 99, 103, 105, 106, 306, 307, 310, 311, 314};
    localparam int TB_EXP[NT] = '{'h400, 'h400, 'hA00, 'hA00, 'h600, 'h600, 'hA01, 'hA07,
                                  'h600, 'h600, 'h500, 'h500, 'hB08, 'hB08, 'h700, 'h500};
    localparam int TB_TAG[NT] = '{1, 2, 2, 4, 4, 4, 5, 5, 4, 3, 3, 6, 6, 4, 4, 4};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0;
    logic       cas_hold = 1'b0;
    logic       cas_n = 1'b1;
    logic       acc_gnt, init_done, pin_own, ras_n;
    logic [7:0] row_addr;

    int checks = 0;
    int fails = 0;
    int cur = 0;
    int strobes = 0;
    int last_addr = -1;
    int prev_addr = -1;
    logic mon_prev = 1'b1;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC(P), .WAKE_CNT(WK), .INTERVAL_CYC(IV), .RAS_LOW_CYC(LO),
        .RAS_HIGH_CYC(HI), .CRP_CYC(CR), .ROW_W(7), .ADDR_W(8), .DEBT_W(4)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .cas_hold(cas_hold), .cas_n(cas_n),
        .acc_gnt(acc_gnt), .init_done(init_done), .pin_own(pin_own), .ras_n(ras_n),
        .row_addr(row_addr)
    );

    // Strobe monitor on the ports
    always @(negedge clk) begin
        if (!rst_n) begin
            strobes  = 0;
            mon_prev = 1'b1;
        end else begin
            if (mon_prev && !ras_n) begin
                strobes   = strobes + 1;
                prev_addr = last_addr;
                last_addr = int'(row_addr);
            end
            mon_prev = ras_n;
        end
    end

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cur);
        end
    endtask

    task automatic goto(input int k);
        if (k > cur) begin
            repeat (k - cur) @(posedge clk);
            @(negedge clk);
            cur = k;
        end
    endtask

    task automatic do_reset(input logic req_in);
        rst_n    = 1'b0;
        acc_req  = req_in;
        cas_hold = 1'b0;
        cas_n    = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur   = 0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0;
        int guard;
        do_reset(1'b0);
        check("R1 gnt", int'(acc_gnt), 0);

        // Start-up and first refresh timeline (R1 R2 R3 R4 R5 R6)
        for (int i = 0; i < NT; i++) begin
            int act;
            int exp;
            goto(TB_CYC[i]);
            exp = TB_EXP[i];
            act = (int'(ras_n) << 10) | (int'(pin_own) << 9) | (int'(init_done) << 8);
            if (exp[11]) act = act | 'h800 | int'(row_addr);
            check(tag_name(TB_TAG[i]), act, exp);
        end

        // R8: grant holds across expiries, no strobe
        acc_req = 1'b1;
        goto(315);
        check("R8 grant", int'(acc_gnt), 1);
        s0 = strobes;
        goto(910);
        check("R8 grant held", int'(acc_gnt), 1);
        check("R8 no strobe", strobes, s0);

        // R9: refresh wins at the boundary
        acc_req = 1'b0;
        goto(911);
        check("R9 idle", int'(acc_gnt), 0);
        acc_req = 1'b1;
        goto(912);
        check("R9 strobe first", int'(ras_n), 0);
        check("R9 no grant", int'(acc_gnt), 0);
        check("R5 addr", int'(row_addr), 9);

        // R7: three owed refreshes served, then grant returns
        goto(936);
        check("R7 grant back", int'(acc_gnt), 1);
        check("R7 strobe count", strobes, s0 + 3);
        check("R7 last row", last_addr, 11);

        // R11: hidden refresh with CAS held low
        goto(1110);
        check("R8 no strobe 2", strobes, s0 + 3);
        cas_n    = 1'b0;
        cas_hold = 1'b1;
        goto(1111);
        check("R11 precharge", (int'(acc_gnt) << 2) | (int'(pin_own) << 1) | int'(ras_n), 3);
        goto(1113);
        check("R11 still high", int'(ras_n), 1);
        goto(1114);
        check("R11 strobe", int'(ras_n), 0);
        check("R11 row", int'(row_addr), 12);
        goto(1118);
        check("R11 rest", (int'(pin_own) << 1) | int'(ras_n), 3);
        goto(1121);
        check("R11 grant back", (int'(acc_gnt) << 1) | int'(pin_own), 2);
        cas_hold = 1'b0;
        acc_req  = 1'b0;

        // R10: CAS low blocks refresh; release starts it after the gap
        goto(1320);
        check("R10 blocked", strobes, s0 + 4);
        check("R10 ras high", int'(ras_n), 1);
        cas_n = 1'b1;
        goto(1322);
        check("R10 gap not met", int'(ras_n), 1);
        goto(1323);
        check("R10 strobe", int'(ras_n), 0);
        check("R10 row", int'(row_addr), 13);

        // R3: requests during start-up are not granted
        do_reset(1'b1);
        check("R1 reset own", int'(pin_own), 0);
        goto(105);
        check("R3 no grant", (int'(init_done) << 1) | int'(acc_gnt), 0);
        goto(106);
        check("R3 init", (int'(init_done) << 1) | int'(acc_gnt), 2);
        goto(107);
        check("R3 grant", int'(acc_gnt), 1);
        acc_req = 1'b0;
        goto(108);
        check("R3 release", int'(acc_gnt), 0);

        // R5: row counter wraps 127 -> 0
        guard = 0;
        while (strobes < 129 && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        check("R5 wrap count", strobes, 129);
        check("R5 row before wrap", prev_addr, 127);
        check("R5 row after wrap", last_addr, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule